// File: doc/BRIEF.md
# Keyboard and Cassette I/O Port

This block is the one I/O location through which a processor reads a 40-key switch matrix and the cassette input, and sets the cassette output and the speaker drive. The port is selected when the I/O request is active and address bit 0 is low. No other address bit takes part in the decode. On a read, the upper byte of the I/O address doubles as the scan pattern. Each of its eight bits enables one group of five keys when it is low. The five sense results come back on the low data bits, with a pressed key reading as 1.

On a write, the block captures the cassette output bit and the speaker bit in a register. It also tracks the direction of the shared tape pin. A read cycle to the port turns the pin into an input and a write cycle turns it into an output. Debouncing and the meaning of each key are left to software.

Top module: `kbd_tape_port`

## Requirements
- R1: A cycle is ignored unless `io_req` is 1 and `addr[0]` is 0. An ignored cycle leaves `tape_out`, `spk_out` and `tape_oe` unchanged, and `rd_data` reads 8'hFF while no read is accepted.
- R2: On an accepted read with exactly one of `addr[15:8]` low, say bit 8+s, `rd_data[i]` for i in 0..4 is 1 exactly when `keys[s*5+i]` is 1.
- R3: When several of `addr[15:8]` are low, `rd_data[4:0]` is the bitwise OR of the five-key groups of all the selected lines.
- R4: When `addr[15:8]` is 8'hFF, an accepted read returns 0 on `rd_data[4:0]`.
- R5: On an accepted read, `rd_data[6]` equals `tape_in`.
- R6: On an accepted read, `rd_data[7]` and `rd_data[5]` are 1.
- R7: On an accepted write, at the next rising clock `tape_out` takes `wr_data[3]` and `spk_out` takes `wr_data[4]`. Between accepted writes both hold their values.
- R8: While `rst_n` is low, `tape_out`, `spk_out` and `tape_oe` are 0.
- R9: After an accepted write, `tape_oe` is 1 from the next rising clock. After an accepted read, `tape_oe` is 0 from the next rising clock.
- R10: A cycle with `rd_en` and `wr_en` both 1 is accepted neither as a read nor as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_req | input | 1 | I/O request, active high |
| rd_en | input | 1 | Read cycle, active high |
| wr_en | input | 1 | Write cycle, active high |
| addr | input | 16 | I/O address; bit 0 is the port select, bits 15..8 are the active-low scan lines |
| wr_data | input | 8 | Write data; bit 3 is the cassette output, bit 4 is the speaker |
| keys | input | 40 | Key closures, 1 = pressed; index is line*5 + sense bit |
| tape_in | input | 1 | Cassette input level |
| rd_data | output | 8 | Read data, combinational from the inputs |
| tape_out | output | 1 | Latched cassette output |
| spk_out | output | 1 | Latched speaker drive |
| tape_oe | output | 1 | Tape pin direction, 1 = driven as an output |

## Verification
The bench builds the block with its default geometry of eight scan lines and five sense bits. At this size every single-line scan with every single key pressed can be checked. So can all 256 scan bytes under a fixed key pattern, which covers every combination of selected lines, including the case with no line selected. The output register is small, so every combination of the two data bits that it captures is written and read back. Odd-address cycles and cycles with both strobes set are interleaved with these writes.

// File: rtl/kbd_tape_pkg.sv
package kbd_tape_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int LINE_N   = 8;
  localparam int SENSE_N  = 5;
  localparam int KEY_N    = LINE_N * SENSE_N;
  localparam int LINE_LSB = ADDR_W - LINE_N;

  localparam int BIT_TAPE_IN  = 6;
  localparam int BIT_TAPE_OUT = 3;
  localparam int BIT_SPEAKER  = 4;

  localparam logic [DATA_W-1:0] IDLE_WORD = '1;

  function automatic logic port_selected(input logic req, input logic a0);
    return req && !a0;
  endfunction

  function automatic logic [DATA_W-1:0] pack_read(input logic [SENSE_N-1:0] rows,
                                                  input logic tin);
    logic [DATA_W-1:0] w;
    w = IDLE_WORD;
    w[SENSE_N-1:0] = rows;
    w[BIT_TAPE_IN] = tin;
    return w;
  endfunction
endpackage

// File: rtl/kbd_port_decode.sv
module kbd_port_decode (
  input  logic io_req,
  input  logic rd_en,
  input  logic wr_en,
  input  logic addr0,
  output logic rd_hit,
  output logic wr_hit
);
  import kbd_tape_pkg::*;

  logic sel;

  always_comb begin
    sel    = port_selected(io_req, addr0);
    rd_hit = sel && rd_en && !wr_en;
    wr_hit = sel && wr_en && !rd_en;
  end
endmodule

// File: rtl/kbd_matrix_sense.sv
module kbd_matrix_sense #(
  parameter int LINES = 8,
  parameter int SENSE = 5
) (
  input  logic [LINES-1:0]       line_n,
  input  logic [LINES*SENSE-1:0] keys,
  output logic [SENSE-1:0]       rows
);
  for (genvar i = 0; i < SENSE; i++) begin : g_sense
    logic [LINES-1:0] hits;
    for (genvar s = 0; s < LINES; s++) begin : g_line
      assign hits[s] = keys[s*SENSE + i] && !line_n[s];
    end
    assign rows[i] = |hits;
  end
endmodule

// File: rtl/kbd_tape_latch.sv
module kbd_tape_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hit,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  output logic          tape_out,
  output logic          spk_out,
  output logic          tape_oe
);
  import kbd_tape_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tape_out <= 1'b0;
      spk_out  <= 1'b0;
      tape_oe  <= 1'b0;
    end else if (wr_hit) begin
      tape_out <= wr_data[BIT_TAPE_OUT];
      spk_out  <= wr_data[BIT_SPEAKER];
      tape_oe  <= 1'b1;
    end else if (rd_hit) begin
      tape_oe  <= 1'b0;
    end
  end
endmodule

// File: rtl/kbd_tape_port.sv
module kbd_tape_port
  import kbd_tape_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [KEY_N-1:0]  keys,
  input  logic              tape_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              tape_out,
  output logic              spk_out,
  output logic              tape_oe
);
  logic               rd_hit;
  logic               wr_hit;
  logic [SENSE_N-1:0] row_bits;

  kbd_port_decode u_dec (
    .io_req (io_req),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr0  (addr[0]),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit)
  );

  kbd_matrix_sense #(.LINES(LINE_N), .SENSE(SENSE_N)) u_sense (
    .line_n (addr[ADDR_W-1:LINE_LSB]),
    .keys   (keys),
    .rows   (row_bits)
  );

  kbd_tape_latch #(.DW(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit),
    .wr_data  (wr_data),
    .tape_out (tape_out),
    .spk_out  (spk_out),
    .tape_oe  (tape_oe)
  );

  always_comb begin
    rd_data = rd_hit ? pack_read(row_bits, tape_in) : IDLE_WORD;
  end
endmodule

// File: rtl/kbd_tape_port_chk.sv
module kbd_tape_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_req,
  input logic [15:0] addr,
  input logic [7:0]  wr_data,
  input logic        tape_in,
  input logic [7:0]  rd_data,
  input logic        tape_out,
  input logic        spk_out,
  input logic        tape_oe,
  input logic        rd_hit,
  input logic        wr_hit
);
  AST_IGNORE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && addr[0]) |=> ($stable(tape_out) && $stable(spk_out) && $stable(tape_oe))); // R1
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data == 8'hFF)); // R1
  AST_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (addr[15:8] == 8'hFF)) |-> (rd_data[4:0] == 5'd0)); // R4
  AST_TAPE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_data[6] == tape_in)); // R5
  AST_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_data[7] && rd_data[5])); // R6
  AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((tape_out == $past(wr_data[3])) && (spk_out == $past(wr_data[4])))); // R7
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> tape_oe); // R9
  AST_OE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> !tape_oe); // R9
  AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit && wr_hit)); // R10
endmodule

bind kbd_tape_port kbd_tape_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_req   (io_req),
  .addr     (addr),
  .wr_data  (wr_data),
  .tape_in  (tape_in),
  .rd_data  (rd_data),
  .tape_out (tape_out),
  .spk_out  (spk_out),
  .tape_oe  (tape_oe),
  .rd_hit   (rd_hit),
  .wr_hit   (wr_hit)
);

// File: tb/kbd_tape_port_bench.sv
`timescale 1ns/1ps
module kbd_tape_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wr_data = 8'h00;
  logic [39:0] keys = '0;
  logic        tape_in = 1'b0;
  logic [7:0]  rd_data;
  logic        tape_out, spk_out, tape_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbd_tape_port u_kbd_tape_port (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .keys(keys), .tape_in(tape_in),
    .rd_data(rd_data), .tape_out(tape_out), .spk_out(spk_out), .tape_oe(tape_oe)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] expect_read(input logic [7:0] hb, input logic [39:0] k,
                                             input logic tin);
    logic [4:0] r;
    r = 5'd0;
    for (int s = 0; s < 8; s++)
      if (hb[s] == 1'b0)
        for (int i = 0; i < 5; i++)
          if (k[s*5+i]) r[i] = 1'b1;
    return {1'b1, tin, 1'b1, r};
  endfunction

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic both);
    @(negedge clk);
    io_req = 1'b1; addr = a; wr_data = d; wr_en = 1'b1; rd_en = both;
    @(negedge clk);
    io_req = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    #1;
  endtask

  task automatic do_read_cycle(input logic [15:0] a);
    @(negedge clk);
    io_req = 1'b1; addr = a; rd_en = 1'b1;
    @(negedge clk);
    io_req = 1'b0; rd_en = 1'b0;
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] ref_st;
    logic       ref_oe;
    #1;
    chk("R8 reset", {5'd0, tape_out, spk_out, tape_oe}, 8'h00);
    chk("R1 idle bus", rd_data, 8'hFF);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after reset", {5'd0, tape_out, spk_out, tape_oe}, 8'h00);

    // R2 R5 R6: one line, one key, all combinations
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        keys = 40'd1 << k;
        tape_in = k[0];
        addr = {~(8'd1 << s), 8'hFE};
        io_req = 1'b1; rd_en = 1'b1;
        #1;
        chk("R2 single line", rd_data, expect_read(addr[15:8], keys, tape_in));
      end
    end

    // R3 R4: every scan byte with a scrambled key pattern
    for (int hb = 0; hb < 256; hb++) begin
      @(negedge clk);
      keys = 40'hA5_3C_96_0F_E1 ^ (40'(hb) * 40'd2654435761);
      tape_in = hb[3];
      addr = {8'(hb), 8'h10};
      #1;
      if (hb == 255) chk("R4 no line", rd_data, expect_read(8'hFF, keys, tape_in));
      else chk("R3 multi line", rd_data, expect_read(8'(hb), keys, tape_in));
    end

    // R1: odd address reads give idle word
    for (int hb = 0; hb < 256; hb += 17) begin
      @(negedge clk);
      addr = {8'(hb), 8'h01};
      #1;
      chk("R1 odd read", rd_data, 8'hFF);
    end
    @(negedge clk);
    io_req = 1'b0; rd_en = 1'b0;
    #1;

    ref_st = 2'b00;
    ref_oe = 1'b0;
    for (int v = 0; v < 16; v++) begin
      logic [7:0] d;
      d = {3'b101, v[1], v[0], 3'b010} ^ {v[2], 7'd0};
      do_write({8'h7F, 8'hFE}, d, 1'b0);
      ref_st = {d[3], d[4]}; ref_oe = 1'b1;
      chk("R7 write capture", {6'd0, tape_out, spk_out}, {6'd0, ref_st});
      chk("R9 oe after write", {7'd0, tape_oe}, {7'd0, ref_oe});

      do_write({8'h00, 8'hFF}, ~d, 1'b0);
      chk("R1 odd write ignored", {5'd0, tape_out, spk_out, tape_oe}, {5'd0, ref_st, ref_oe});

      do_write({8'hFE, 8'h00}, ~d, 1'b1);
      chk("R10 dual strobe ignored", {5'd0, tape_out, spk_out, tape_oe}, {5'd0, ref_st, ref_oe});

      if (v[3]) begin
        do_read_cycle({8'hFD, 8'hFE});
        ref_oe = 1'b0;
        chk("R9 oe after read", {5'd0, tape_out, spk_out, tape_oe}, {5'd0, ref_st, ref_oe});
      end
    end

    @(negedge clk);
    io_req = 1'b1; rd_en = 1'b1; wr_en = 1'b1; addr = 16'h00FE;
    #1;
    chk("R10 dual strobe read", rd_data, 8'hFF);
    io_req = 1'b0; rd_en = 1'b0; wr_en = 1'b0;

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 reset again", {5'd0, tape_out, spk_out, tape_oe}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule